// File: doc/BRIEF.md
# Trap Entry and Privilege Delegation Unit

This block takes a trap request and redirects the hart to a handler. A request is a single-cycle strobe with an interrupt/exception flag, a cause code, a trap value and the address of the trapping instruction. The unit first works out which privilege level (machine, supervisor or user) takes the trap. It does this from the current privilege and from two pairs of delegation masks, one pair for interrupts and one for exceptions. It then updates that level's cause, return-address and trap-value registers, and saves and clears that level's interrupt-enable bit. The new privilege is set to the handler level.

One cycle after the request it issues a redirect strobe together with the handler address. For interrupts the address can be vectored per cause. Asynchronous reset puts the hart in machine mode at a fixed reset vector. A plain write/read port, addressed by a small selector, preloads and observes the state. It is not a full CSR file.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted and after its release with no trap: privilege is machine (2'b11), the machine interrupt enable and the memory-privilege override bit are 0, the machine cause register reads 0, `redirect_o` is 0 and `redirect_pc_o` equals `RESET_VEC`. Privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R2: The handler is machine by default. It is supervisor when the current privilege is not machine and the code's bit is set in the machine delegation mask of the trap's kind (selector 3 for interrupts, 2 for exceptions). A trap taken in machine mode always stays in machine mode.
- R3: When the current privilege is user and the code's bit is set in the supervisor delegation mask of the trap's kind (selector 5 for interrupts, 4 for exceptions), the handler is user. This holds whatever the machine mask says.
- R4: Machine handler: MPP (status bits 12:11) takes the previous privilege, MPIE (bit 7) takes the prior MIE (bit 3), and MIE is cleared.
- R5: Supervisor handler: SPP (bit 8) takes bit 0 of the previous privilege, SPIE (bit 5) takes the prior SIE (bit 1), and SIE is cleared.
- R6: User handler: UPIE (bit 4) takes the prior UIE (bit 0), and UIE is cleared.
- R7: The handler level's cause register gets the code in its low bits, the interrupt flag in bit XLEN-1, and zeros elsewhere.
- R8: The handler level's return-address register gets `trap_pc_i` and its trap-value register gets `trap_val_i`. The privilege becomes the handler level. The same registers of the other two levels are unchanged.
- R9: The handler address is the level's vector register with bits 1:0 cleared. When the trap is an interrupt and the vector's bits 1:0 equal 1, 4*code is added. Exceptions, and vector modes 0, 2 and 3, always use the base.
- R10: `redirect_o` is high for exactly the one cycle after the cycle in which `trap_valid_i` is sampled. `redirect_pc_o` holds the handler address from that cycle on.
- R11: The setup port writes on `csr_we_i` and reads combinationally. Selector 0 is status, 1 is privilege, 2 to 5 are the delegation masks, and 8+4*L+k is level L's (user 0, supervisor 1, machine 2) cause, return address, trap value or vector for k = 0 to 3. A privilege write of 2'b10 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | One-cycle trap request |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_code_i | input | $clog2(XLEN) | Cause code |
| trap_val_i | input | XLEN | Trap value |
| trap_pc_i | input | XLEN | Address of the trapping instruction |
| csr_we_i | input | 1 | Setup write enable |
| csr_sel_i | input | 5 | Setup register selector |
| csr_wdata_i | input | XLEN | Setup write data |
| csr_rdata_o | output | XLEN | Setup read data |
| priv_o | output | 2 | Current privilege |
| redirect_o | output | 1 | Redirect strobe |
| redirect_pc_o | output | XLEN | Handler or reset address |

## Verification
The bench builds the unit with XLEN = 32 and RESET_VEC = 32'h0000_1000. At that width a 5-bit code reaches bit 31 of the delegation masks and the top vectored offset of 124. The interrupt flag lands in the top bit at 32-bit width. The vector table pairs each start privilege with delegation bits that are set only in the mask of the opposite trap kind or only in the mask of the right kind. This exposes a mask picked by the wrong kind, a supervisor bit honoured outside user mode, and vector modes 2 and 3 taken as vectored.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] LVL_USER    = 2'b00;
  localparam logic [1:0] LVL_SUPER   = 2'b01;
  localparam logic [1:0] LVL_MACHINE = 2'b11;
  localparam int NUM_LVL = 3;

  localparam logic [4:0] SEL_STATUS   = 5'd0;
  localparam logic [4:0] SEL_PRIV     = 5'd1;
  localparam logic [4:0] SEL_EDLG_M   = 5'd2;
  localparam logic [4:0] SEL_IDLG_M   = 5'd3;
  localparam logic [4:0] SEL_EDLG_S   = 5'd4;
  localparam logic [4:0] SEL_IDLG_S   = 5'd5;
  localparam int         SEL_LVL_BASE = 8;

  localparam int ST_UIE = 0, ST_SIE = 1, ST_MIE = 3, ST_UPIE = 4, ST_SPIE = 5;
  localparam int ST_MPIE = 7, ST_SPP = 8, ST_MPP_LO = 11, ST_MPRV = 17;

  function automatic logic [1:0] lvl_idx(input logic [1:0] p);
    return (p == LVL_MACHINE) ? 2'd2 : (p == LVL_SUPER) ? 2'd1 : 2'd0;
  endfunction
endpackage

// File: rtl/trap_deleg.sv
module trap_deleg
  import trap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int CODE_W = $clog2(XLEN)
) (
  input  logic [1:0]        cur_priv_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   edlg_m_i,
  input  logic [XLEN-1:0]   idlg_m_i,
  input  logic [XLEN-1:0]   edlg_s_i,
  input  logic [XLEN-1:0]   idlg_s_i,
  output logic [1:0]        hdl_priv_o
);
  logic m_bit, s_bit;

  always_comb begin
    m_bit = irq_i ? idlg_m_i[code_i] : edlg_m_i[code_i];
    s_bit = irq_i ? idlg_s_i[code_i] : edlg_s_i[code_i];
    hdl_priv_o = LVL_MACHINE;
    if (cur_priv_i != LVL_MACHINE && m_bit) hdl_priv_o = LVL_SUPER;
    if (cur_priv_i == LVL_USER && s_bit)    hdl_priv_o = LVL_USER;
  end
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
  parameter int XLEN   = 64,
  parameter int CODE_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]   tvec_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   pc_o
);
  logic [XLEN-1:0] base, off;

  always_comb begin
    base = {tvec_i[XLEN-1:2], 2'b00};
    off  = '0;
    // only mode 1 vectors; 2 and 3 fall back to direct
    if (irq_i && tvec_i[1:0] == 2'b01) off[CODE_W+1:0] = {code_i, 2'b00};
    pc_o = base + off;
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'h0000_1000)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     trap_valid_i,
  input  logic                     trap_irq_i,
  input  logic [$clog2(XLEN)-1:0]  trap_code_i,
  input  logic [XLEN-1:0]          trap_val_i,
  input  logic [XLEN-1:0]          trap_pc_i,
  input  logic                     csr_we_i,
  input  logic [4:0]               csr_sel_i,
  input  logic [XLEN-1:0]          csr_wdata_i,
  output logic [XLEN-1:0]          csr_rdata_o,
  output logic [1:0]               priv_o,
  output logic                     redirect_o,
  output logic [XLEN-1:0]          redirect_pc_o
);
  localparam int CODE_W = $clog2(XLEN);

  logic [XLEN-1:0] cause_q [NUM_LVL];
  logic [XLEN-1:0] epc_q   [NUM_LVL];
  logic [XLEN-1:0] tval_q  [NUM_LVL];
  logic [XLEN-1:0] tvec_q  [NUM_LVL];
  logic [XLEN-1:0] edlg_m_q, idlg_m_q, edlg_s_q, idlg_s_q;
  logic [1:0]      priv_q, mpp_q;
  logic            uie_q, sie_q, mie_q, upie_q, spie_q, mpie_q, spp_q, mprv_q;
  logic            redirect_q;
  logic [XLEN-1:0] redirect_pc_q;

  logic [1:0]      hdl_priv, hdl_idx, cur_idx;
  logic [XLEN-1:0] vec_pc, cause_val, status_w;

  trap_deleg #(.XLEN(XLEN), .CODE_W(CODE_W)) u_deleg (
    .cur_priv_i(priv_q), .irq_i(trap_irq_i), .code_i(trap_code_i),
    .edlg_m_i(edlg_m_q), .idlg_m_i(idlg_m_q),
    .edlg_s_i(edlg_s_q), .idlg_s_i(idlg_s_q),
    .hdl_priv_o(hdl_priv)
  );

  assign hdl_idx = lvl_idx(hdl_priv);
  assign cur_idx = lvl_idx(priv_q);

  trap_vec #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .tvec_i(tvec_q[hdl_idx]), .irq_i(trap_irq_i), .code_i(trap_code_i),
    .pc_o(vec_pc)
  );

  always_comb begin
    cause_val = '0;
    cause_val[CODE_W-1:0] = trap_code_i;
    cause_val[XLEN-1]     = trap_irq_i;
  end

  always_comb begin
    status_w = '0;
    status_w[ST_UIE]  = uie_q;
    status_w[ST_SIE]  = sie_q;
    status_w[ST_MIE]  = mie_q;
    status_w[ST_UPIE] = upie_q;
    status_w[ST_SPIE] = spie_q;
    status_w[ST_MPIE] = mpie_q;
    status_w[ST_SPP]  = spp_q;
    status_w[ST_MPP_LO+1:ST_MPP_LO] = mpp_q;
    status_w[ST_MPRV] = mprv_q;
  end

  // per-level trap registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < NUM_LVL; l++) begin
        cause_q[l] <= '0;
        epc_q[l]   <= '0;
        tval_q[l]  <= '0;
        tvec_q[l]  <= '0;
      end
    end else begin
      for (int l = 0; l < NUM_LVL; l++) begin
        if (trap_valid_i && hdl_idx == 2'(l)) begin
          cause_q[l] <= cause_val;
          epc_q[l]   <= trap_pc_i;
          tval_q[l]  <= trap_val_i;
        end else if (csr_we_i) begin
          if (csr_sel_i == 5'(SEL_LVL_BASE + 4*l))     cause_q[l] <= csr_wdata_i;
          if (csr_sel_i == 5'(SEL_LVL_BASE + 4*l + 1)) epc_q[l]   <= csr_wdata_i;
          if (csr_sel_i == 5'(SEL_LVL_BASE + 4*l + 2)) tval_q[l]  <= csr_wdata_i;
        end
        if (csr_we_i && csr_sel_i == 5'(SEL_LVL_BASE + 4*l + 3)) tvec_q[l] <= csr_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edlg_m_q <= '0; idlg_m_q <= '0; edlg_s_q <= '0; idlg_s_q <= '0;
    end else if (csr_we_i) begin
      if (csr_sel_i == SEL_EDLG_M) edlg_m_q <= csr_wdata_i;
      if (csr_sel_i == SEL_IDLG_M) idlg_m_q <= csr_wdata_i;
      if (csr_sel_i == SEL_EDLG_S) edlg_s_q <= csr_wdata_i;
      if (csr_sel_i == SEL_IDLG_S) idlg_s_q <= csr_wdata_i;
    end
  end

  // privilege and status fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= LVL_MACHINE;
      {uie_q, sie_q, mie_q, upie_q, spie_q, mpie_q, spp_q, mprv_q} <= '0;
      mpp_q  <= LVL_USER;
    end else if (trap_valid_i) begin
      priv_q <= hdl_priv;
      unique case (hdl_priv)
        LVL_MACHINE: begin mpp_q <= priv_q;    mpie_q <= mie_q; mie_q <= 1'b0; end
        LVL_SUPER:   begin spp_q <= priv_q[0]; spie_q <= sie_q; sie_q <= 1'b0; end
        default:     begin upie_q <= uie_q;    uie_q <= 1'b0; end
      endcase
    end else if (csr_we_i) begin
      if (csr_sel_i == SEL_PRIV && csr_wdata_i[1:0] != 2'b10) priv_q <= csr_wdata_i[1:0];
      if (csr_sel_i == SEL_STATUS) begin
        uie_q  <= csr_wdata_i[ST_UIE];
        sie_q  <= csr_wdata_i[ST_SIE];
        mie_q  <= csr_wdata_i[ST_MIE];
        upie_q <= csr_wdata_i[ST_UPIE];
        spie_q <= csr_wdata_i[ST_SPIE];
        mpie_q <= csr_wdata_i[ST_MPIE];
        spp_q  <= csr_wdata_i[ST_SPP];
        mpp_q  <= csr_wdata_i[ST_MPP_LO+1:ST_MPP_LO];
        mprv_q <= csr_wdata_i[ST_MPRV];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q    <= 1'b0;
      redirect_pc_q <= RESET_VEC;
    end else begin
      redirect_q <= trap_valid_i;
      if (trap_valid_i) redirect_pc_q <= vec_pc;
    end
  end

  always_comb begin
    logic [4:0] off;
    off = csr_sel_i - 5'(SEL_LVL_BASE);
    csr_rdata_o = '0;
    case (csr_sel_i)
      SEL_STATUS: csr_rdata_o = status_w;
      SEL_PRIV:   csr_rdata_o[1:0] = priv_q;
      SEL_EDLG_M: csr_rdata_o = edlg_m_q;
      SEL_IDLG_M: csr_rdata_o = idlg_m_q;
      SEL_EDLG_S: csr_rdata_o = edlg_s_q;
      SEL_IDLG_S: csr_rdata_o = idlg_s_q;
      default:
        if (csr_sel_i >= 5'(SEL_LVL_BASE) && off[4:2] < 3'(NUM_LVL)) begin
          case (off[1:0])
            2'd0:    csr_rdata_o = cause_q[off[3:2]];
            2'd1:    csr_rdata_o = epc_q[off[3:2]];
            2'd2:    csr_rdata_o = tval_q[off[3:2]];
            default: csr_rdata_o = tvec_q[off[3:2]];
          endcase
        end
    endcase
  end

  assign priv_o        = priv_q;
  assign redirect_o    = redirect_q;
  assign redirect_pc_o = redirect_pc_q;

  assert_priv_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_q != 2'b10);
  assert_hdl_not_lower_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |-> hdl_idx >= cur_idx);
  assert_user_from_user_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && hdl_priv == LVL_USER) |-> priv_q == LVL_USER);
  assert_mie_saved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && hdl_priv == LVL_MACHINE) |=> (!mie_q && mpie_q == $past(mie_q)));
  assert_sie_saved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && hdl_priv == LVL_SUPER) |=> (!sie_q && spie_q == $past(sie_q)));
  assert_priv_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> priv_q == $past(hdl_priv));
  assert_pc_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_q |-> redirect_pc_q[1:0] == 2'b00);
  assert_redirect_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_q |-> $past(trap_valid_i));
endmodule

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  // {start_priv[13:12], irq[11], code[10:6], mdel[5], sdel[4], tvec_mode[3:2], exp_priv[1:0]}
  localparam logic [13:0] VECS [12] = '{
    {2'b11, 1'b0, 5'd2,  1'b1, 1'b1, 2'd0, 2'b11},
    {2'b01, 1'b0, 5'd8,  1'b1, 1'b0, 2'd0, 2'b01},
    {2'b00, 1'b0, 5'd8,  1'b1, 1'b1, 2'd1, 2'b00},
    {2'b00, 1'b1, 5'd5,  1'b1, 1'b0, 2'd1, 2'b01},
    {2'b00, 1'b1, 5'd9,  1'b0, 1'b1, 2'd1, 2'b00},
    {2'b01, 1'b1, 5'd1,  1'b1, 1'b1, 2'd1, 2'b01},
    {2'b11, 1'b1, 5'd7,  1'b0, 1'b0, 2'd1, 2'b11},
    {2'b00, 1'b0, 5'd13, 1'b0, 1'b0, 2'd1, 2'b11},
    {2'b00, 1'b1, 5'd11, 1'b0, 1'b0, 2'd2, 2'b11},
    {2'b01, 1'b1, 5'd3,  1'b0, 1'b1, 2'd3, 2'b11},
    {2'b00, 1'b1, 5'd31, 1'b1, 1'b1, 2'd0, 2'b00},
    {2'b01, 1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 2'b11}
  };
  localparam logic [31:0] BASES [3] = '{32'h2000_0300, 32'h4000_0200, 32'h8000_0100};

  logic clk = 0, rst_n = 0;
  logic trap_valid = 0, trap_irq = 0;
  logic [4:0] trap_code = '0;
  logic [31:0] trap_val = '0, trap_pc = '0;
  logic csr_we = 0;
  logic [4:0] csr_sel = '0;
  logic [31:0] csr_wdata = '0, csr_rdata, redirect_pc;
  logic [1:0] priv;
  logic redirect;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .RESET_VEC(RVEC)) u_trap_entry_unit (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(trap_valid), .trap_irq_i(trap_irq),
    .trap_code_i(trap_code), .trap_val_i(trap_val), .trap_pc_i(trap_pc),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .priv_o(priv), .redirect_o(redirect),
    .redirect_pc_o(redirect_pc)
  );

  function automatic int lv(input logic [1:0] p);
    return (p == 2'b11) ? 2 : (p == 2'b01) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    csr_sel = 5'(sel); csr_wdata = d; csr_we = 1;
    @(posedge clk); @(negedge clk);
    csr_we = 0;
  endtask

  task automatic rd(input int sel, output logic [31:0] v);
    csr_sel = 5'(sel); #1; v = csr_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #(CLK_PERIOD * 2);
    // R1 reset state, held and after release
    rd(0, v); chk("R1", "status in reset", v, 0);
    chk("R1", "priv in reset", priv, 2'b11);
    @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1", "priv", priv, 2'b11);
    chk("R1", "redirect", redirect, 0);
    chk("R1", "redirect_pc", redirect_pc, RVEC);
    rd(16, v); chk("R1", "mcause", v, 0);

    for (int i = 0; i < 12; i++) begin
      logic [1:0] sp, ep; logic irq, md, sd; logic [4:0] code; logic [1:0] mode;
      logic [31:0] bit_m, exp_pc, exp_st, exp_cause;
      int el;
      {sp, irq, code, md, sd, mode, ep} = VECS[i];
      el = lv(ep);
      bit_m = 32'd1 << code;
      wr(0, 32'h0000_000B);
      wr(1, {30'd0, sp});
      // delegation bit placed only in the mask of the trap's own kind when set, else in the other kind
      wr(irq ? 3 : 2, md ? bit_m : 0); wr(irq ? 2 : 3, md ? 0 : bit_m);
      wr(irq ? 5 : 4, sd ? bit_m : 0); wr(irq ? 4 : 5, sd ? 0 : bit_m);
      for (int l = 0; l < 3; l++) begin
        wr(11 + 4*l, BASES[l] | {30'd0, mode});
        wr(9 + 4*l, 32'hDEAD_0000 + l);
      end
      trap_valid = 1; trap_irq = irq; trap_code = code;
      trap_pc = 32'h1234_5670 + 32'(i*4); trap_val = 32'hA5A5_0000 + 32'(i);
      @(posedge clk); @(negedge clk);
      trap_valid = 0;
      exp_pc = BASES[el] + ((irq && mode == 2'd1) ? 32'(code) * 4 : 0);
      exp_cause = {irq, 26'd0, code};
      if (ep == 2'b11)      exp_st = (32'hB & ~32'h8) | 32'h80 | (32'(sp) << 11);
      else if (ep == 2'b01) exp_st = (32'hB & ~32'h2) | 32'h20 | (32'(sp[0]) << 8);
      else                  exp_st = (32'hB & ~32'h1) | 32'h10;
      chk("R2 R3", "handler priv", priv, ep);
      chk("R10", "redirect strobe", redirect, 1);
      chk("R9", "handler pc", redirect_pc, exp_pc);
      rd(0, v);       chk("R4 R5 R6", "status", v, exp_st);
      rd(8 + 4*el, v);  chk("R7", "cause", v, exp_cause);
      rd(9 + 4*el, v);  chk("R8", "epc", v, trap_pc);
      rd(10 + 4*el, v); chk("R8", "tval", v, trap_val);
      for (int l = 0; l < 3; l++)
        if (l != el) begin rd(9 + 4*l, v); chk("R8", "other epc", v, 32'hDEAD_0000 + l); end
      @(negedge clk);
      chk("R10", "strobe drop", redirect, 0);
      chk("R10", "pc hold", redirect_pc, exp_pc);
    end

    // R11 setup port: readback and illegal privilege code ignored
    wr(15, 32'hCAFE_F00D); rd(15, v); chk("R11", "stvec readback", v, 32'hCAFE_F00D);
    wr(1, 32'd1); wr(1, 32'd2); chk("R11", "priv 2'b10 ignored", priv, 2'b01);

    // R1 reset after activity clears MIE, MPRV, mcause and returns to reset vector
    wr(0, 32'h0002_0008); wr(16, 32'h0000_0055); wr(1, 32'd0);
    #2 rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1", "priv after reset", priv, 2'b11);
    chk("R1", "pc after reset", redirect_pc, RVEC);
    rd(0, v);  chk("R1", "mie/mprv after reset", v & 32'h0002_0008, 0);
    rd(16, v); chk("R1", "mcause after reset", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule